// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block turns a 32-bit virtual address into a physical address. The top three address bits pick one of four fixed windows. Two of them are kernel-only windows that map straight onto the bottom 512 MB of physical memory. One of those two is cacheable and the other is not, so the same physical byte can be reached through either window and through any TLB entry that points at it. The other two windows, the low 2 GB user window and the top 1 GB kernel window, go through a small fully associative TLB. The TLB is keyed by the 20-bit virtual page number of a 4 KB page.

Each lookup request is accepted in one cycle and the result is registered, so it appears on the outputs one clock later. All TLB entries are compared in parallel. A separate write port loads one TLB entry by index: its virtual page, its frame number and its valid bit. The outputs are the physical address, a cacheable flag and three fault flags. The fault flags report a TLB miss, a privilege violation, and an ambiguous lookup that matched several entries.

Top module: `vseg_xlate`

## Requirements
- R1: After synchronous reset, `rsp_valid_o`, `pa_o` and all flags are 0. `rsp_valid_o` is 1 exactly in the cycle after a cycle with `req_i`=1, and the other outputs then hold that request's result.
- R2: In kernel mode (`user_i`=0), an address with bits [31:29]=3'b100 gives `pa_o` = VA − 0x8000_0000 and `cacheable_o`=1, with all fault flags 0.
- R3: In kernel mode, an address with bits [31:29]=3'b101 gives `pa_o` = VA − 0xA000_0000 and `cacheable_o`=0, with all fault flags 0.
- R4: An address with bit 31=0 (any mode), or bits [31:30]=2'b11 in kernel mode, that matches exactly one valid entry on VA[31:12] gives `pa_o` = {frame, VA[11:0]} and `cacheable_o`=1.
- R5: Such a mapped address that matches no valid entry gives `miss_o`=1, with `pa_o`=0 and `cacheable_o`=0.
- R6: In user mode (`user_i`=1), any address with bit 31=1 gives `addr_err_o`=1, with `pa_o`=0, `cacheable_o`=0 and `miss_o`=0, whatever the TLB holds.
- R7: A mapped address that matches two or more valid entries gives `multi_hit_o`=1, with `miss_o`=0, `pa_o`=0 and `cacheable_o`=0.
- R8: With `wr_en_i`=1, entry `wr_idx_i` takes `wr_vpn_i`, `wr_pfn_i` and `wr_vld_i` at the clock edge. A lookup in that same cycle still sees the old contents. Writing `wr_vld_i`=0 removes the entry's mapping. Reset clears every valid bit.
- R9: At most one of `miss_o`, `addr_err_o` and `multi_hit_o` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Lookup request |
| user_i | input | 1 | 1 = user mode, 0 = kernel mode |
| va_i | input | 32 | Virtual address |
| wr_en_i | input | 1 | TLB entry write strobe |
| wr_idx_i | input | 6 | TLB entry index to write |
| wr_vpn_i | input | 20 | Virtual page number to store |
| wr_pfn_i | input | 20 | Frame number to store |
| wr_vld_i | input | 1 | Valid bit to store |
| rsp_valid_o | output | 1 | Result valid, one cycle after a request |
| pa_o | output | 32 | Physical address |
| cacheable_o | output | 1 | Access may be cached |
| miss_o | output | 1 | No valid TLB entry for a mapped address |
| addr_err_o | output | 1 | Kernel address used in user mode |
| multi_hit_o | output | 1 | Several valid TLB entries matched |

## Verification
The assertions check the response timing, the two direct-window subtractions with their cacheability, the user-mode privilege fault and the mutual exclusion of the three fault flags on every cycle. These checks look only at ports. TLB hits, misses and multiple matches depend on the entries that were written earlier, so only the bench's scenarios show them. The bench fills all 64 entries and sweeps every one in both mapped windows. It also shows several virtual addresses reaching the same physical address, entry invalidation and overwrite, and a lookup issued in the same cycle as a write.

// File: rtl/vseg_xlate_pkg.sv
package vseg_xlate_pkg;

    localparam int VA_W  = 32;
    localparam int OFS_W = 12;
    localparam int PN_W  = VA_W - OFS_W;

    localparam logic [VA_W-1:0] DIRECT_C_BASE = 32'h8000_0000;
    localparam logic [VA_W-1:0] DIRECT_U_BASE = 32'hA000_0000;

    typedef enum logic [1:0] {
        WIN_USER     = 2'd0,
        WIN_DIRECT_C = 2'd1,
        WIN_DIRECT_U = 2'd2,
        WIN_KMAPPED  = 2'd3
    } win_e;

    typedef struct packed {
        logic            vld;
        logic [PN_W-1:0] vpn;
        logic [PN_W-1:0] pfn;
    } tlb_ent_t;

    typedef struct packed {
        logic [VA_W-1:0] pa;
        logic            cach;
        logic            miss;
        logic            aerr;
        logic            mhit;
    } xlate_t;

    function automatic win_e window_of(input logic [VA_W-1:0] va);
        unique case (va[VA_W-1 -: 3])
            3'b100:          return WIN_DIRECT_C;
            3'b101:          return WIN_DIRECT_U;
            3'b110, 3'b111:  return WIN_KMAPPED;
            default:         return WIN_USER;
        endcase
    endfunction

    function automatic logic [VA_W-1:0] join_pa(input logic [PN_W-1:0] pfn,
                                                 input logic [VA_W-1:0] va);
        return {pfn, va[OFS_W-1:0]};
    endfunction

endpackage

// File: rtl/vseg_tlb_store.sv
module vseg_tlb_store
    import vseg_xlate_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  tlb_ent_t                     wr_ent,
    output tlb_ent_t [ENTRIES-1:0]       ents
);

    tlb_ent_t [ENTRIES-1:0] ents_q;

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
            always_ff @(posedge clk) begin
                if (rst) begin
                    ents_q[e] <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                    ents_q[e] <= wr_ent;
                end
            end
        end
    endgenerate

    assign ents = ents_q;

endmodule

// File: rtl/vseg_tlb_match.sv
module vseg_tlb_match
    import vseg_xlate_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  tlb_ent_t [ENTRIES-1:0] ents,
    input  logic [PN_W-1:0]        vpn,
    output logic                   hit,
    output logic                   multi,
    output logic [PN_W-1:0]        pfn
);

    logic [ENTRIES-1:0] hit_vec;
    logic [PN_W-1:0]    sel_pfn [ENTRIES];

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
            assign hit_vec[e] = ents[e].vld && (ents[e].vpn == vpn);
            assign sel_pfn[e] = hit_vec[e] ? ents[e].pfn : '0;
        end
    endgenerate

    always_comb begin
        pfn = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            pfn = pfn | sel_pfn[e];
        end
    end

    assign hit   = |hit_vec;
    assign multi = ($countones(hit_vec) > 1);

endmodule

// File: rtl/vseg_resolve.sv
module vseg_resolve
    import vseg_xlate_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  logic            user,
    input  logic            hit,
    input  logic            multi,
    input  logic [PN_W-1:0] pfn,
    output xlate_t          res
);

    win_e win;

    always_comb begin
        win = window_of(va);
        res = '0;
        if (user && va[VA_W-1]) begin
            res.aerr = 1'b1;
        end else begin
            unique case (win)
                WIN_DIRECT_C: begin
                    res.pa   = va - DIRECT_C_BASE;
                    res.cach = 1'b1;
                end
                WIN_DIRECT_U: begin
                    res.pa   = va - DIRECT_U_BASE;
                end
                default: begin
                    if (!hit) begin
                        res.miss = 1'b1;
                    end else if (multi) begin
                        res.mhit = 1'b1;
                    end else begin
                        res.pa   = join_pa(pfn, va);
                        res.cach = 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/vseg_xlate.sv
module vseg_xlate
    import vseg_xlate_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic             user_i,
    input  logic [31:0]      va_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [19:0]      wr_vpn_i,
    input  logic [19:0]      wr_pfn_i,
    input  logic             wr_vld_i,
    output logic             rsp_valid_o,
    output logic [31:0]      pa_o,
    output logic             cacheable_o,
    output logic             miss_o,
    output logic             addr_err_o,
    output logic             multi_hit_o
);

    tlb_ent_t [ENTRIES-1:0] ents;
    tlb_ent_t               wr_ent;
    logic                   hit, multi;
    logic [PN_W-1:0]        pfn;
    xlate_t                 res_d, res_q;
    logic                   vld_q;

    assign wr_ent = '{vld: wr_vld_i, vpn: wr_vpn_i, pfn: wr_pfn_i};

    vseg_tlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en_i),
        .wr_idx (wr_idx_i),
        .wr_ent (wr_ent),
        .ents   (ents)
    );

    vseg_tlb_match #(.ENTRIES(ENTRIES)) u_match (
        .ents  (ents),
        .vpn   (va_i[VA_W-1:OFS_W]),
        .hit   (hit),
        .multi (multi),
        .pfn   (pfn)
    );

    vseg_resolve u_resolve (
        .va    (va_i),
        .user  (user_i),
        .hit   (hit),
        .multi (multi),
        .pfn   (pfn),
        .res   (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= req_i;
            if (req_i) res_q <= res_d;
        end
    end

    assign rsp_valid_o = vld_q;
    assign pa_o        = res_q.pa;
    assign cacheable_o = res_q.cach;
    assign miss_o      = res_q.miss;
    assign addr_err_o  = res_q.aerr;
    assign multi_hit_o = res_q.mhit;

endmodule

// File: rtl/vseg_xlate_chk.sv
module vseg_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_i,
    input logic        user_i,
    input logic [31:0] va_i,
    input logic        rsp_valid_o,
    input logic [31:0] pa_o,
    input logic        cacheable_o,
    input logic        miss_o,
    input logic        addr_err_o,
    input logic        multi_hit_o
);

    a_r1_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_i |=> rsp_valid_o);

    a_r1_no_resp_without_req: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> !rsp_valid_o);

    a_r2_cached_window: assert property (@(posedge clk) disable iff (rst)
        (req_i && !user_i && va_i[31:29] == 3'b100)
        |=> (pa_o == $past(va_i) - 32'h8000_0000) && cacheable_o && !miss_o && !addr_err_o);

    a_r3_uncached_window: assert property (@(posedge clk) disable iff (rst)
        (req_i && !user_i && va_i[31:29] == 3'b101)
        |=> (pa_o == $past(va_i) - 32'hA000_0000) && !cacheable_o && !miss_o && !addr_err_o);

    a_r6_user_privilege: assert property (@(posedge clk) disable iff (rst)
        (req_i && user_i && va_i[31])
        |=> addr_err_o && !miss_o && !cacheable_o && (pa_o == 32'h0));

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({miss_o, addr_err_o, multi_hit_o}));

endmodule

bind vseg_xlate vseg_xlate_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .user_i      (user_i),
    .va_i        (va_i),
    .rsp_valid_o (rsp_valid_o),
    .pa_o        (pa_o),
    .cacheable_o (cacheable_o),
    .miss_o      (miss_o),
    .addr_err_o  (addr_err_o),
    .multi_hit_o (multi_hit_o)
);

// File: tb/vseg_xlate_test.sv
`timescale 1ns/1ps
module vseg_xlate_test;

    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0, user_i = 1'b0;
    logic [31:0] va_i = '0;
    logic        wr_en_i = 1'b0, wr_vld_i = 1'b0;
    logic [5:0]  wr_idx_i = '0;
    logic [19:0] wr_vpn_i = '0, wr_pfn_i = '0;
    logic        rsp_valid_o, cacheable_o, miss_o, addr_err_o, multi_hit_o;
    logic [31:0] pa_o;

    int checks = 0;
    int fails  = 0;

    logic        m_vld [N];
    logic [19:0] m_vpn [N];
    logic [19:0] m_pfn [N];

    always #2.5 clk = ~clk;

    vseg_xlate uut (
        .clk(clk), .rst(rst), .req_i(req_i), .user_i(user_i), .va_i(va_i),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_vpn_i(wr_vpn_i),
        .wr_pfn_i(wr_pfn_i), .wr_vld_i(wr_vld_i),
        .rsp_valid_o(rsp_valid_o), .pa_o(pa_o), .cacheable_o(cacheable_o),
        .miss_o(miss_o), .addr_err_o(addr_err_o), .multi_hit_o(multi_hit_o)
    );

    // {pa, cacheable, miss, addr_err, multi_hit}
    function automatic logic [35:0] expect_of(input logic [31:0] va, input logic um);
        int n = 0;
        logic [19:0] f = '0;
        if (um && va[31]) return {32'h0, 4'b0010};
        if (va[31:29] == 3'b100) return {va - 32'h8000_0000, 4'b1000};
        if (va[31:29] == 3'b101) return {va - 32'hA000_0000, 4'b0000};
        for (int e = 0; e < N; e++) begin
            if (m_vld[e] && m_vpn[e] == va[31:12]) begin
                n++;
                f = m_pfn[e];
            end
        end
        if (n == 0) return {32'h0, 4'b0100};
        if (n > 1)  return {32'h0, 4'b0001};
        return {f, va[11:0], 4'b1000};
    endfunction

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input int idx, input logic [19:0] vpn,
                            input logic [19:0] pfn, input logic v);
        @(negedge clk);
        wr_en_i = 1'b1; wr_idx_i = 6'(idx); wr_vpn_i = vpn; wr_pfn_i = pfn; wr_vld_i = v;
        @(negedge clk);
        wr_en_i = 1'b0;
        m_vld[idx] = v; m_vpn[idx] = vpn; m_pfn[idx] = pfn;
    endtask

    task automatic lookup(input string req, input logic [31:0] va, input logic um);
        logic [35:0] exp;
        @(negedge clk);
        req_i = 1'b1; user_i = um; va_i = va;
        exp = expect_of(va, um);
        @(negedge clk);
        req_i = 1'b0;
        check(req, {pa_o, cacheable_o, miss_o, addr_err_o, multi_hit_o}, exp);
        check("R1", {35'h0, rsp_valid_o}, 36'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int e = 0; e < N; e++) begin
            m_vld[e] = 1'b0; m_vpn[e] = '0; m_pfn[e] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", {pa_o, cacheable_o, miss_o, addr_err_o, multi_hit_o}, 36'h0);
        check("R1", {35'h0, rsp_valid_o}, 36'h0);

        // R5 empty TLB misses in both mapped windows
        lookup("R5", 32'h0040_0123, 1'b0);
        lookup("R5", 32'hC000_0FFF, 1'b0);

        // R8 fill every entry: half user pages, half top-kernel pages
        for (int e = 0; e < N; e++) begin
            if (e < 32) do_write(e, 20'h00400 + 20'(e), 20'h01000 + 20'(3*e), 1'b1);
            else        do_write(e, 20'hC0000 + 20'(e), 20'h02000 + 20'(5*e), 1'b1);
        end

        // R4 sweep every entry
        for (int e = 0; e < N; e++) begin
            logic [31:0] va = {m_vpn[e], 12'(e * 61)};
            lookup("R4", va, 1'b0);
            if (e < 32) lookup("R4", va, 1'b1);
            else        lookup("R6", va, 1'b1);
        end

        // R2/R3 direct window sweep, kernel mode; R6 same addresses user mode
        for (int i = 0; i < 24; i++) begin
            logic [28:0] off = 29'(i * 32'h0123_4567);
            lookup("R2", {3'b100, off}, 1'b0);
            lookup("R3", {3'b101, off}, 1'b0);
            lookup("R6", {3'b100, off}, 1'b1);
            lookup("R6", {3'b111, off}, 1'b1);
        end
        lookup("R2", 32'h8000_0000, 1'b0);
        lookup("R2", 32'h9FFF_FFFF, 1'b0);
        lookup("R3", 32'hA000_0000, 1'b0);
        lookup("R3", 32'hBFFF_FFFF, 1'b0);

        // R4 aliasing: same physical address via TLB and both direct windows
        do_write(7, 20'h7FFFE, 20'h01113, 1'b1);
        lookup("R4", 32'h7FFF_EFA0, 1'b1);
        lookup("R2", 32'h8111_3FA0, 1'b0);
        lookup("R3", 32'hA111_3FA0, 1'b0);

        // R5 miss on unloaded pages
        lookup("R5", 32'h0050_0000, 1'b1);
        lookup("R5", 32'hFFFF_F000, 1'b0);

        // R7 two entries share a page
        do_write(9, m_vpn[10], 20'h0ABCD, 1'b1);
        lookup("R7", {m_vpn[10], 12'h444}, 1'b0);
        lookup("R7", {m_vpn[10], 12'h444}, 1'b1);

        // R8 invalidate one of them: unique hit again
        do_write(9, m_vpn[10], 20'h0ABCD, 1'b0);
        lookup("R8", {m_vpn[10], 12'h444}, 1'b0);
        // R8 invalidate last copy: miss
        do_write(10, m_vpn[10], m_pfn[10], 1'b0);
        lookup("R8", {m_vpn[10], 12'h444}, 1'b0);

        // R8 lookup in the same cycle as a write sees old contents
        begin
            logic [35:0] exp;
            @(negedge clk);
            wr_en_i = 1'b1; wr_idx_i = 6'd40; wr_vpn_i = m_vpn[40];
            wr_pfn_i = 20'h0F0F0; wr_vld_i = 1'b1;
            req_i = 1'b1; user_i = 1'b0; va_i = {m_vpn[40], 12'h010};
            exp = expect_of(va_i, 1'b0);
            @(negedge clk);
            wr_en_i = 1'b0; req_i = 1'b0;
            m_pfn[40] = 20'h0F0F0;
            check("R8", {pa_o, cacheable_o, miss_o, addr_err_o, multi_hit_o}, exp);
        end
        lookup("R8", {m_vpn[40], 12'h010}, 1'b0);

        // R1 no request: response valid drops
        @(negedge clk);
        check("R1", {35'h0, rsp_valid_o}, 36'h0);

        // R8 reset clears all entries
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int e = 0; e < N; e++) m_vld[e] = 1'b0;
        lookup("R8", {20'h00400, 12'h0}, 1'b0);
        lookup("R8", 32'hC000_0000 + 32'(40 << 12), 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule